// File: doc/BRIEF.md
# Flash Command Sequencer (Slave Side)

This block sits on the slave side of a two-phase flash data bus. A master puts a command and an address on the bus (the address phase). The sequencer accepts it on a clock edge where its ready output is high. The command then runs in its data phase, which ends on the next edge where ready is high. The master may present the next address phase while the current data phase is still running, so transfers overlap. The sequencer drives control strobes for a behavioural flash macro with fixed read, program and erase latencies, and holds ready low while the macro is busy.

Ready is low after reset while the macro finishes its power-up initialization. A command offered in that time waits on the bus and is not executed. Consecutive row writes keep the macro in programming mode. When a row write finishes, the sequencer looks at the command waiting on the bus and decides whether to stay in programming mode or to close it, which costs a recovery interval. The sequencer can also run housekeeping of its own. A housekeeping request is held until the bus is idle, and ready stays low for the whole housekeeping run.

Top module: `flash_cmd_seq`

## Requirements
- R1: A command is accepted on an edge where ready_o is 1 and cmd_i is non-zero. Its data phase ends on the next edge with ready_o at 1. The following address phase is accepted on that same edge, so back-to-back reads take exactly RD_LAT+1 cycles each.
- R2: From reset, ready_o is 0 for exactly INIT_LAT cycles. During reset, err_o, mac_prog_o and mac_hk_o are 0.
- R3: A command presented during initialization starts no macro strobe before ready_o rises. It runs normally afterwards.
- R4: The cmd_i encodings are 3'b001 read, 3'b010 row write and 3'b011 erase. In the data phase, ready_o is low for RD_LAT, WR_LAT or ER_LAT cycles respectively. A read returns the stored word on rdata_o in the last data-phase cycle. A row write stores wdata_i, which is held through the data phase. An erase sets the word to all ones.
- R5: Through a run of back-to-back row writes, mac_prog_o stays 1 in every cycle, and each write's data phase has WR_LAT low cycles.
- R6: If the command waiting on the bus when a row write finishes is not a row write, mac_prog_o falls. Ready stays low for REC_LAT further cycles before that command's own latency starts. This also applies when the bus is idle.
- R7: cmd_i 3'b000 is idle. The codes 3'b100 to 3'b111 finish at once with err_o at 1 in their single ready cycle and start no macro strobe.
- R8: Housekeeping starts only after a cycle in which no data phase is running and cmd_i is idle. A request made while the bus is busy is kept until then. While mac_hk_o is 1, ready_o is 0, for HK_LAT cycles.
- R9: At most one of mac_rd_o, mac_wr_o, mac_er_o and mac_hk_o is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Address-phase command code |
| addr_i | input | ADDR_W | Address-phase word address |
| wdata_i | input | DATA_W | Write data, held through the data phase |
| hk_req_i | input | 1 | Internal housekeeping trigger |
| ready_o | output | 1 | High when the current data phase ends and an address phase is accepted |
| err_o | output | 1 | Error response for an unknown command code |
| rdata_o | output | DATA_W | Read data, valid in the last data-phase cycle of a read |
| mac_prog_o | output | 1 | Macro programming mode |
| mac_rd_o | output | 1 | Macro read strobe |
| mac_wr_o | output | 1 | Macro program strobe |
| mac_er_o | output | 1 | Macro erase strobe |
| mac_hk_o | output | 1 | Macro housekeeping in progress |

## Verification
The command path is driven with several input patterns:
- Pipelined read runs measure the exact cycles per transfer, which separates true overlap from a serialized bus.
- Row-write bursts, and writes followed by an erase, a read, an illegal code or an idle bus, separate staying in programming mode from closing it with recovery.
- A command offered during initialization, and a housekeeping request raised under continuous traffic, separate deferred execution from premature execution.
- Data read back after each write and erase tells apart stores that landed from stores that were dropped.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE  = 3'b000,
    CMD_READ  = 3'b001,
    CMD_ROWWR = 3'b010,
    CMD_ERASE = 3'b011
  } fcs_cmd_e;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_EXEC,
    ST_DONE,
    ST_RECOV,
    ST_HK
  } fcs_state_e;

  function automatic int fcs_max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fcs_cmd_decode.sv
module fcs_cmd_decode
  import fcs_pkg::*;
#(
  parameter int CW     = 4,
  parameter int RD_LAT = 3,
  parameter int WR_LAT = 5,
  parameter int ER_LAT = 8
) (
  input  logic [2:0]    cmd,
  output logic          present,
  output logic          legal,
  output logic          rowwr,
  output logic [CW-1:0] lat_last
);
  always_comb begin
    present  = (cmd != CMD_IDLE);
    legal    = 1'b1;
    rowwr    = 1'b0;
    lat_last = '0;
    case (cmd)
      CMD_READ:  lat_last = CW'(RD_LAT - 1);
      CMD_ROWWR: begin
        lat_last = CW'(WR_LAT - 1);
        rowwr    = 1'b1;
      end
      CMD_ERASE: lat_last = CW'(ER_LAT - 1);
      default:   legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcs_hk_gate.sv
module fcs_hk_gate (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic start,
  output logic want
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= (pend | req) & ~start;
  end

  assign want = pend | req;
endmodule

// File: rtl/fcs_macro_model.sv
module fcs_macro_model #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)    mem[addr] <= wdata;
    if (rd_en) rdata     <= mem[addr];
  end
endmodule

// File: rtl/fcs_seq_ctrl.sv
module fcs_seq_ctrl
  import fcs_pkg::*;
#(
  parameter int AW       = 6,
  parameter int CW       = 4,
  parameter int INIT_LAT = 12,
  parameter int REC_LAT  = 4,
  parameter int HK_LAT   = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cmd,
  input  logic [AW-1:0] addr,
  input  logic          in_present,
  input  logic          in_legal,
  input  logic          in_rowwr,
  input  logic [CW-1:0] in_last,
  input  logic          hk_want,
  output fcs_state_e    state,
  output logic [2:0]    cur_cmd,
  output logic [AW-1:0] cur_addr,
  output logic          ready,
  output logic          err,
  output logic          prog,
  output logic          hk_start
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cur_last;
  logic          cur_legal;
  logic          held;
  logic          wr_close;

  // a finishing row write with anything other than another row write waiting
  assign wr_close = (state == ST_DONE) && (cur_cmd == CMD_ROWWR) && !in_rowwr;
  assign hk_start = (state == ST_IDLE) && !in_present && hk_want;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_INIT;
      cnt       <= '0;
      ready     <= 1'b0;
      err       <= 1'b0;
      prog      <= 1'b0;
      held      <= 1'b0;
      cur_cmd   <= CMD_IDLE;
      cur_addr  <= '0;
      cur_last  <= '0;
      cur_legal <= 1'b0;
    end else begin
      err <= 1'b0;
      case (state)
        ST_INIT: begin
          if (cnt == CW'(INIT_LAT - 1)) begin
            state <= ST_IDLE;
            ready <= 1'b1;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_IDLE, ST_DONE: begin
          cnt <= '0;
          if (in_present) begin
            cur_cmd   <= cmd;
            cur_addr  <= addr;
            cur_last  <= in_last;
            cur_legal <= in_legal;
          end
          if (wr_close) begin
            prog  <= 1'b0;
            state <= ST_RECOV;
            ready <= 1'b0;
            held  <= in_present;
          end else if (in_present) begin
            if (!in_legal) begin
              state <= ST_DONE;
              ready <= 1'b1;
              err   <= 1'b1;
            end else begin
              state <= ST_EXEC;
              ready <= 1'b0;
              if (in_rowwr) prog <= 1'b1;
            end
          end else if (hk_start) begin
            state <= ST_HK;
            ready <= 1'b0;
          end else begin
            state <= ST_IDLE;
            ready <= 1'b1;
          end
        end
        ST_EXEC: begin
          if (cnt == cur_last) begin
            state <= ST_DONE;
            ready <= 1'b1;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RECOV: begin
          if (cnt == CW'(REC_LAT - 1)) begin
            cnt  <= '0;
            held <= 1'b0;
            if (!held) begin
              state <= ST_IDLE;
              ready <= 1'b1;
            end else if (!cur_legal) begin
              state <= ST_DONE;
              ready <= 1'b1;
              err   <= 1'b1;
            end else begin
              state <= ST_EXEC;
              ready <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HK: begin
          if (cnt == CW'(HK_LAT - 1)) begin
            state <= ST_IDLE;
            ready <= 1'b1;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_INIT;
          ready <= 1'b0;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int RD_LAT   = 3,
  parameter int WR_LAT   = 5,
  parameter int ER_LAT   = 8,
  parameter int REC_LAT  = 4,
  parameter int INIT_LAT = 12,
  parameter int HK_LAT   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hk_req_i,
  output logic              ready_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mac_prog_o,
  output logic              mac_rd_o,
  output logic              mac_wr_o,
  output logic              mac_er_o,
  output logic              mac_hk_o
);
  localparam int MAX_OP  = fcs_max2(fcs_max2(RD_LAT, WR_LAT), ER_LAT);
  localparam int MAX_AUX = fcs_max2(fcs_max2(REC_LAT, INIT_LAT), HK_LAT);
  localparam int CW      = $clog2(fcs_max2(MAX_OP, MAX_AUX) + 1);

  logic              in_present, in_legal, in_rowwr;
  logic [CW-1:0]     in_last;
  logic              hk_want, hk_start;
  fcs_state_e        state;
  logic [2:0]        cur_cmd;
  logic [ADDR_W-1:0] cur_addr;
  logic              init_phase;
  logic              mem_we, mem_rd;
  logic [DATA_W-1:0] mem_wdata;

  fcs_cmd_decode #(
    .CW(CW), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .ER_LAT(ER_LAT)
  ) u_dec (
    .cmd(cmd_i), .present(in_present), .legal(in_legal),
    .rowwr(in_rowwr), .lat_last(in_last)
  );

  fcs_hk_gate u_hk (
    .clk(clk), .rst(rst), .req(hk_req_i), .start(hk_start), .want(hk_want)
  );

  fcs_seq_ctrl #(
    .AW(ADDR_W), .CW(CW), .INIT_LAT(INIT_LAT), .REC_LAT(REC_LAT), .HK_LAT(HK_LAT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmd(cmd_i), .addr(addr_i),
    .in_present(in_present), .in_legal(in_legal), .in_rowwr(in_rowwr),
    .in_last(in_last), .hk_want(hk_want), .state(state),
    .cur_cmd(cur_cmd), .cur_addr(cur_addr), .ready(ready_o), .err(err_o),
    .prog(mac_prog_o), .hk_start(hk_start)
  );

  assign mac_rd_o   = (state == ST_EXEC) && (cur_cmd == CMD_READ);
  assign mac_wr_o   = (state == ST_EXEC) && (cur_cmd == CMD_ROWWR);
  assign mac_er_o   = (state == ST_EXEC) && (cur_cmd == CMD_ERASE);
  assign mac_hk_o   = (state == ST_HK);
  assign init_phase = (state == ST_INIT);

  // stores commit on the edge that closes the data phase
  assign mem_rd    = mac_rd_o;
  assign mem_we    = (state == ST_DONE) &&
                     ((cur_cmd == CMD_ROWWR) || (cur_cmd == CMD_ERASE));
  assign mem_wdata = (cur_cmd == CMD_ERASE) ? {DATA_W{1'b1}} : wdata_i;

  fcs_macro_model #(.AW(ADDR_W), .DW(DATA_W)) u_mac (
    .clk(clk), .rd_en(mem_rd), .we(mem_we), .addr(cur_addr),
    .wdata(mem_wdata), .rdata(rdata_o)
  );
endmodule

// File: rtl/flash_cmd_seq_checks.sv
module flash_cmd_seq_checks (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cmd_i,
  input logic       ready_o,
  input logic       err_o,
  input logic       mac_prog_o,
  input logic       mac_rd_o,
  input logic       mac_wr_o,
  input logic       mac_er_o,
  input logic       mac_hk_o,
  input logic       init_phase
);
  a_r2_init_not_ready: assert property (@(posedge clk) disable iff (rst)
    init_phase |-> !ready_o);

  a_r3_no_op_during_init: assert property (@(posedge clk) disable iff (rst)
    init_phase |-> !(mac_rd_o || mac_wr_o || mac_er_o || mac_hk_o));

  a_r5_prog_kept: assert property (@(posedge clk) disable iff (rst)
    (mac_prog_o && ready_o && cmd_i == 3'b010) |=> mac_prog_o);

  a_r6_exit_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(mac_prog_o) |-> !ready_o);

  a_r7_err_in_ready: assert property (@(posedge clk) disable iff (rst)
    err_o |-> ready_o);

  a_r8_hk_busy: assert property (@(posedge clk) disable iff (rst)
    mac_hk_o |-> !ready_o);

  a_r8_hk_idle_start: assert property (@(posedge clk) disable iff (rst)
    $rose(mac_hk_o) |-> ($past(cmd_i) == 3'b000 && $past(ready_o)));

  a_r9_single_op: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mac_rd_o, mac_wr_o, mac_er_o, mac_hk_o}));
endmodule

bind flash_cmd_seq flash_cmd_seq_checks u_chk (
  .clk(clk), .rst(rst), .cmd_i(cmd_i), .ready_o(ready_o), .err_o(err_o),
  .mac_prog_o(mac_prog_o), .mac_rd_o(mac_rd_o), .mac_wr_o(mac_wr_o),
  .mac_er_o(mac_er_o), .mac_hk_o(mac_hk_o), .init_phase(init_phase)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  localparam int AW = 6, DW = 16;
  localparam int RD = 3, WR = 5, ER = 8, REC = 4, INI = 12, HK = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic [2:0]    cmd_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i;
  logic          hk_req_i;
  logic          ready_o, err_o, mac_prog_o, mac_rd_o, mac_wr_o, mac_er_o, mac_hk_o;
  logic [DW-1:0] rdata_o;

  flash_cmd_seq #(
    .ADDR_W(AW), .DATA_W(DW), .RD_LAT(RD), .WR_LAT(WR), .ER_LAT(ER),
    .REC_LAT(REC), .INIT_LAT(INI), .HK_LAT(HK)
  ) uut (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .hk_req_i(hk_req_i), .ready_o(ready_o), .err_o(err_o), .rdata_o(rdata_o),
    .mac_prog_o(mac_prog_o), .mac_rd_o(mac_rd_o), .mac_wr_o(mac_wr_o),
    .mac_er_o(mac_er_o), .mac_hk_o(mac_hk_o)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int hk_viol = 0, hk_cyc = 0, prog_drop = 0, hk_early = 0, multi = 0;
  logic watch_prog = 1'b0, watch_nohk = 1'b0, arm_prog = 1'b0, hk_at_start = 1'b0;

  logic [2:0]    q_cmd [8];
  logic [AW-1:0] q_addr[8];
  logic [DW-1:0] q_wd  [8];
  logic [DW-1:0] r_rd  [8];
  logic          r_err [8];
  int            r_wait[8];
  int            t_start, t_end;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mac_hk_o && ready_o) hk_viol++;
    if (mac_hk_o) hk_cyc++;
    if (watch_prog && !mac_prog_o) prog_drop++;
    if (watch_nohk && mac_hk_o) hk_early++;
    if ($countones({mac_rd_o, mac_wr_o, mac_er_o, mac_hk_o}) > 1) multi++;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void put(input int i, input logic [2:0] c,
                              input logic [AW-1:0] a, input logic [DW-1:0] d);
    q_cmd[i] = c; q_addr[i] = a; q_wd[i] = d;
  endfunction

  // pipelined master: next address phase overlaps the current data phase
  task automatic run_seq(input int n);
    @(negedge clk);
    cmd_i = q_cmd[0]; addr_i = q_addr[0];
    if (hk_at_start) hk_req_i = 1'b1;
    while (!ready_o) @(negedge clk);
    t_start = cyc;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hk_req_i = 1'b0;
      if (arm_prog && i == 0) watch_prog = 1'b1;
      wdata_i = q_wd[i];
      if (i + 1 < n) begin cmd_i = q_cmd[i+1]; addr_i = q_addr[i+1]; end
      else cmd_i = 3'b000;
      r_wait[i] = 0;
      while (!ready_o) begin r_wait[i]++; @(negedge clk); end
      r_rd[i] = rdata_o; r_err[i] = err_o;
    end
    t_end = cyc;
    watch_prog = 1'b0;
  endtask

  task automatic t_reset_init();
    int low, seen;
    rst = 1'b1; cmd_i = 3'b000; addr_i = '0; wdata_i = '0; hk_req_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 ready in reset", ready_o, 0);
    chk("R2 err in reset", err_o, 0);
    chk("R2 prog in reset", mac_prog_o, 0);
    chk("R2 hk in reset", mac_hk_o, 0);
    rst = 1'b0;
    cmd_i = 3'b011; addr_i = 6'd5;
    low = 0; seen = 0;
    while (!ready_o && low < 100) begin
      low++;
      if (mac_rd_o || mac_wr_o || mac_er_o || mac_hk_o) seen++;
      @(negedge clk);
    end
    chk("R2 init low cycles", low, INI);
    chk("R3 no strobe during init", seen, 0);
    @(negedge clk);
    cmd_i = 3'b000;
    low = 0;
    while (!ready_o) begin low++; @(negedge clk); end
    chk("R3 deferred erase latency", low, ER);
    put(0, 3'b001, 6'd5, '0);
    run_seq(1);
    chk("R4 erased word reads ones", r_rd[0], 16'hFFFF);
  endtask

  task automatic t_pipeline();
    put(0, 3'b010, 6'd1, 16'h1111);
    put(1, 3'b010, 6'd2, 16'h2222);
    put(2, 3'b010, 6'd3, 16'hA5C3);
    run_seq(3);
    chk("R4 write latency", r_wait[0], WR);
    put(0, 3'b001, 6'd1, '0);
    put(1, 3'b001, 6'd2, '0);
    put(2, 3'b001, 6'd3, '0);
    run_seq(3);
    chk("R4 read latency", r_wait[0], RD);
    chk("R4 read data 1", r_rd[0], 16'h1111);
    chk("R4 read data 2", r_rd[1], 16'h2222);
    chk("R4 read data 3", r_rd[2], 16'hA5C3);
    chk("R1 overlapped read timing", t_end - t_start, 3 * (RD + 1));
    put(0, 3'b011, 6'd2, '0);
    put(1, 3'b001, 6'd2, '0);
    run_seq(2);
    chk("R4 erase latency", r_wait[0], ER);
    chk("R4 read after erase", r_rd[1], 16'hFFFF);
  endtask

  task automatic t_row_burst();
    for (int i = 0; i < 4; i++) put(i, 3'b010, AW'(40 + i), DW'(16'h1000 + i));
    prog_drop = 0; arm_prog = 1'b1;
    run_seq(4);
    arm_prog = 1'b0;
    chk("R5 prog never dropped", prog_drop, 0);
    for (int i = 0; i < 4; i++) chk("R5 burst write latency", r_wait[i], WR);
    @(negedge clk);
    chk("R6 prog closed after burst", mac_prog_o, 0);
    chk("R6 busy during recovery", ready_o, 0);
    for (int i = 0; i < 4; i++) put(i, 3'b001, AW'(40 + i), '0);
    run_seq(4);
    for (int i = 0; i < 4; i++) chk("R5 burst data", r_rd[i], 16'h1000 + i);
  endtask

  task automatic t_prog_exit();
    put(0, 3'b010, 6'd20, 16'h5A5A);
    put(1, 3'b001, 6'd20, '0);
    put(2, 3'b011, 6'd20, '0);
    put(3, 3'b001, 6'd20, '0);
    run_seq(4);
    chk("R6 read after write waits recovery", r_wait[1], REC + RD);
    chk("R6 data before erase", r_rd[1], 16'h5A5A);
    chk("R6 erase latency after read", r_wait[2], ER);
    chk("R6 data after erase", r_rd[3], 16'hFFFF);
    put(0, 3'b010, 6'd21, 16'h0F0F);
    put(1, 3'b011, 6'd22, '0);
    run_seq(2);
    chk("R6 erase after write waits recovery", r_wait[1], REC + ER);
  endtask

  task automatic t_bad_code();
    int s;
    put(0, 3'b001, 6'd3, '0);
    put(1, 3'b101, 6'd3, '0);
    put(2, 3'b111, 6'd3, '0);
    put(3, 3'b001, 6'd3, '0);
    run_seq(4);
    chk("R7 legal err", r_err[0], 0);
    chk("R7 code 101 err", r_err[1], 1);
    chk("R7 code 111 err", r_err[2], 1);
    chk("R7 code 101 no wait", r_wait[1], 0);
    chk("R7 read after bad", r_rd[3], 16'hA5C3);
    put(0, 3'b010, 6'd30, 16'hBEEF);
    put(1, 3'b100, 6'd30, '0);
    run_seq(2);
    chk("R7 bad after write waits recovery", r_wait[1], REC);
    chk("R7 bad after write err", r_err[1], 1);
    @(negedge clk);
    cmd_i = 3'b110;
    s = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (mac_rd_o || mac_wr_o || mac_er_o) s++;
    end
    cmd_i = 3'b000;
    chk("R7 bad code no strobe", s, 0);
    put(0, 3'b001, 6'd30, '0);
    run_seq(1);
    chk("R7 write before bad kept", r_rd[0], 16'hBEEF);
  endtask

  task automatic t_hk_pending();
    int n;
    hk_cyc = 0; hk_early = 0; hk_viol = 0;
    put(0, 3'b011, 6'd50, '0);
    put(1, 3'b001, 6'd3, '0);
    put(2, 3'b001, 6'd1, '0);
    hk_at_start = 1'b1; watch_nohk = 1'b1;
    run_seq(3);
    hk_at_start = 1'b0; watch_nohk = 1'b0;
    chk("R8 no hk while bus busy", hk_early, 0);
    chk("R8 erase latency with hk pending", r_wait[0], ER);
    n = 0;
    while (!mac_hk_o && n < 50) begin @(negedge clk); n++; end
    chk("R8 pending hk starts after idle cycle", n, 2);
    put(0, 3'b001, 6'd2, '0);
    run_seq(1);
    chk("R8 hk cycle count", hk_cyc, HK);
    chk("R8 ready low during hk", hk_viol, 0);
    chk("R8 read after hk", r_rd[0], 16'hFFFF);
  endtask

  task automatic t_hk_idle();
    int low;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    hk_cyc = 0; hk_viol = 0;
    hk_req_i = 1'b1;
    @(negedge clk);
    hk_req_i = 1'b0;
    chk("R8 idle hk starts", mac_hk_o, 1);
    low = 0;
    while (!ready_o && low < 50) begin low++; @(negedge clk); end
    chk("R8 idle hk ready-low cycles", low, HK);
    chk("R8 no ready during idle hk", hk_viol, 0);
    chk("R9 single macro operation", multi, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_init();
    t_pipeline();
    t_row_burst();
    t_prog_exit();
    t_bad_code();
    t_hk_pending();
    t_hk_idle();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule